// File: doc/BRIEF.md
# Cascadable Dual Interval Timer

This block holds two 8-bit up-counters. Each counter advances on a chosen edge of a chosen count source. A counter runs until its value matches a compare latch. At that point the counter returns to zero, the latch takes a fresh value from the data register, a sticky interrupt flag is set and, if enabled, a square-wave output flips. The two counters work either as separate 8-bit interval timers or as one 16-bit timer. In the 16-bit case counter 0 is the low byte, counter 1 is the high byte, and timer 0's controls drive the pair.

Software reaches the block through a small register port: one write strobe, a 3-bit address and 8-bit data. Read data comes back one cycle after the address is presented. The count sources are seven one-cycle tick enables from a shared prescaler, plus one asynchronous external clock pin. The external pin is resynchronized inside the block, and only timer 0 (or the 16-bit pair) may select it.

Top module: `casc_interval_timer`

## Requirements
- R1: On a count event the selected counter advances by one. A count event is a rising edge of the selected source when the control edge bit is 0, and a falling edge when it is 1. Source codes 0 to 6 pick `tick_in[code]`.
- R2: Source code 7 on timer 0 uses `ext_clk` after a two-flop synchronizer. Source code 7 on timer 1 in 8-bit mode never produces a count event.
- R3: A count event that finds the counter equal to its compare latch clears the counter to 0 instead of advancing it. A latch value L therefore gives a period of L+1 events.
- R4: The compare latch is reloaded from its data register only on a match or when the timer is started. A data write made while running takes effect after the next match.
- R5: When the mode bit (bit 7 of CTL0) is set, the counters form one 16-bit counter, low byte from counter 0 and high byte from counter 1. This counter is clocked by timer 0's source and edge and gated by timer 0's run bit. It matches on all 16 bits, and a match sets only flag 0.
- R6: The flag bit (bit 6 of a control register) is set by a match. It stays set until a control write puts 0 in that bit. Writing 1 leaves it unchanged. The interrupt output equals flag AND enable (bit 5) and is registered one cycle after the flag.
- R7: When the wave enable is set, each match of the chosen source flips `wave_out`. The source is timer 1 if the select bit is 1, otherwise timer 0, and the combined match in 16-bit mode. When the wave enable is clear, `wave_out` holds.
- R8: Clearing the run bit (bit 0) holds the counter. Writing the run bit from 0 to 1 clears the counter and reloads the latch.
- R9: After reset, every register, both counters, both interrupts and `wave_out` are 0.
- R10: The register map is as follows. Address 0 is CTL0 and address 1 is CTL1. Their fields are run [0], edge [1], source [4:2], enable [5], flag [6] and mode [7], with mode in CTL0 only. Address 2 is DATA0 and address 3 is DATA1. Address 4 is COUNT0 and address 5 is COUNT1, both read-only. Address 6 is WAVE, with enable in bit 0 and select in bit 1. `bus_rdata` shows the addressed value one cycle after the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_in | input | 7 | Prescaler tick enables, source codes 0 to 6 |
| ext_clk | input | 1 | Asynchronous external count clock |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Registered read data |
| irq0 | output | 1 | Timer 0 / 16-bit interrupt |
| irq1 | output | 1 | Timer 1 interrupt |
| wave_out | output | 1 | Square-wave output |

## Verification
The timing from a stimulus to each result is fixed:
- An internal tick moves the counter at the edge that samples the tick, or at the following edge for falling-edge mode.
- An external edge lands two edges later, after the synchronizer.
- A flag and the wave flip appear at the matching edge, and the interrupt one edge after that.
- Read data appears one edge after the address.

The bench drives every input at a falling clock edge. Each tick pulse is followed by an idle cycle, so both edge modes finish before the next stimulus. Counters, flags and interrupts are sampled only after a full read cycle, which always lies past the last of those edges.

// File: rtl/cit_pkg.sv
`timescale 1ns/1ps
package cit_pkg;
  localparam int BUS_W  = 8;
  localparam int ADDR_W = 3;
  localparam int SEL_W  = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CTL0 = 3'd0,
    A_CTL1 = 3'd1,
    A_DAT0 = 3'd2,
    A_DAT1 = 3'd3,
    A_CNT0 = 3'd4,
    A_CNT1 = 3'd5,
    A_WAVE = 3'd6
  } reg_addr_e;

  typedef struct packed {
    logic             cascade;
    logic             flag;
    logic             ien;
    logic [SEL_W-1:0] src;
    logic             fall;
    logic             run;
  } ctl_t;
endpackage

// File: rtl/cit_edge_src.sv
`timescale 1ns/1ps
module cit_edge_src #(
  parameter int N_TICK  = 7,
  parameter int SEL_W   = 3,
  parameter bit HAS_EXT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_TICK-1:0] tick_in,
  input  logic              ext_in,
  input  logic [SEL_W-1:0]  sel,
  input  logic              fall,
  output logic              step
);
  logic [1:0] sync_q;
  logic       prev_q;
  logic       lvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= 2'b00;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], ext_in};
      prev_q <= lvl;
    end
  end

  always_comb begin
    lvl = 1'b0;
    for (int i = 0; i < N_TICK; i++) begin
      if (sel == SEL_W'(i)) lvl = tick_in[i];
    end
    if (sel == SEL_W'(N_TICK)) lvl = HAS_EXT ? sync_q[1] : 1'b0;
  end

  assign step = fall ? (prev_q & ~lvl) : (lvl & ~prev_q);
endmodule

// File: rtl/cit_count8.sv
`timescale 1ns/1ps
module cit_count8 #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             wrap,
  input  logic             restart,
  input  logic [CNT_W-1:0] data,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] lat
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      lat <= '0;
    end else if (restart || wrap) begin
      cnt <= '0;
      lat <= data;
    end else if (step) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/casc_interval_timer.sv
`timescale 1ns/1ps
module casc_interval_timer
  import cit_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int N_TICK = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_TICK-1:0] tick_in,
  input  logic              ext_clk,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              irq0,
  output logic              irq1,
  output logic              wave_out
);
  ctl_t             ctl0, ctl1, wctl;
  logic [CNT_W-1:0] dat0, dat1, cnt0, cnt1, lat0, lat1;
  logic             wave_en, wave_sel, wave_q, irq0_q, irq1_q;
  logic [BUS_W-1:0] rdata_q;
  logic             ev0, ev1, step0, step1, m0, m1, m16, wrap0, wrap1;
  logic             restart0, restart1, wave_hit, mode16;
  logic             wr_ctl0, wr_ctl1, wr_dat0, wr_dat1, wr_wave;

  assign wctl    = ctl_t'(bus_wdata);
  assign wr_ctl0 = bus_wr && (bus_addr == A_CTL0);
  assign wr_ctl1 = bus_wr && (bus_addr == A_CTL1);
  assign wr_dat0 = bus_wr && (bus_addr == A_DAT0);
  assign wr_dat1 = bus_wr && (bus_addr == A_DAT1);
  assign wr_wave = bus_wr && (bus_addr == A_WAVE);
  assign mode16  = ctl0.cascade;

  // count sources: only channel 0 may reach the external pin
  cit_edge_src #(.N_TICK(N_TICK), .SEL_W(SEL_W), .HAS_EXT(1'b1)) u_src0 (
    .clk(clk), .rst(rst), .tick_in(tick_in), .ext_in(ext_clk),
    .sel(ctl0.src), .fall(ctl0.fall), .step(ev0));
  cit_edge_src #(.N_TICK(N_TICK), .SEL_W(SEL_W), .HAS_EXT(1'b0)) u_src1 (
    .clk(clk), .rst(rst), .tick_in(tick_in), .ext_in(ext_clk),
    .sel(ctl1.src), .fall(ctl1.fall), .step(ev1));

  // match and cascade logic
  assign restart0 = wr_ctl0 && wctl.run && !ctl0.run;
  assign restart1 = (wr_ctl1 && wctl.run && !ctl1.run) || (restart0 && wctl.cascade);
  assign step0    = ev0 && ctl0.run;
  assign m0       = step0 && !mode16 && (cnt0 == lat0);
  assign m16      = step0 && mode16 && (cnt0 == lat0) && (cnt1 == lat1);
  assign m1       = ev1 && ctl1.run && !mode16 && (cnt1 == lat1);
  assign wrap0    = m0 || m16;
  assign wrap1    = m1 || m16;
  assign step1    = mode16 ? (step0 && (cnt0 == {CNT_W{1'b1}})) : (ev1 && ctl1.run);

  cit_count8 #(.CNT_W(CNT_W)) u_cnt0 (
    .clk(clk), .rst(rst), .step(step0), .wrap(wrap0), .restart(restart0),
    .data(dat0), .cnt(cnt0), .lat(lat0));
  cit_count8 #(.CNT_W(CNT_W)) u_cnt1 (
    .clk(clk), .rst(rst), .step(step1), .wrap(wrap1), .restart(restart1),
    .data(dat1), .cnt(cnt1), .lat(lat1));

  // control and data registers; a match setting a flag beats a clear
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl0     <= '0;
      ctl1     <= '0;
      dat0     <= '0;
      dat1     <= '0;
      wave_en  <= 1'b0;
      wave_sel <= 1'b0;
    end else begin
      if (wr_ctl0) begin
        ctl0      <= wctl;
        ctl0.flag <= (ctl0.flag && wctl.flag) || wrap0;
      end else begin
        ctl0.flag <= ctl0.flag || wrap0;
      end
      if (wr_ctl1) begin
        ctl1         <= wctl;
        ctl1.cascade <= 1'b0;
        ctl1.flag    <= (ctl1.flag && wctl.flag) || m1;
      end else begin
        ctl1.flag <= ctl1.flag || m1;
      end
      if (wr_dat0) dat0 <= CNT_W'(bus_wdata);
      if (wr_dat1) dat1 <= CNT_W'(bus_wdata);
      if (wr_wave) begin
        wave_en  <= bus_wdata[0];
        wave_sel <= bus_wdata[1];
      end
    end
  end

  // registered outputs
  assign wave_hit = mode16 ? m16 : (wave_sel ? m1 : m0);

  always_ff @(posedge clk) begin
    if (rst) begin
      wave_q <= 1'b0;
      irq0_q <= 1'b0;
      irq1_q <= 1'b0;
    end else begin
      if (wave_en && wave_hit) wave_q <= ~wave_q;
      irq0_q <= ctl0.flag && ctl0.ien;
      irq1_q <= ctl1.flag && ctl1.ien;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else begin
      case (bus_addr)
        A_CTL0:  rdata_q <= BUS_W'(ctl0);
        A_CTL1:  rdata_q <= BUS_W'(ctl1);
        A_DAT0:  rdata_q <= BUS_W'(dat0);
        A_DAT1:  rdata_q <= BUS_W'(dat1);
        A_CNT0:  rdata_q <= BUS_W'(cnt0);
        A_CNT1:  rdata_q <= BUS_W'(cnt1);
        A_WAVE:  rdata_q <= BUS_W'({wave_sel, wave_en});
        default: rdata_q <= '0;
      endcase
    end
  end

  assign bus_rdata = rdata_q;
  assign irq0      = irq0_q;
  assign irq1      = irq1_q;
  assign wave_out  = wave_q;
endmodule

// File: rtl/cit_checker.sv
`timescale 1ns/1ps
module cit_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] cnt0,
  input logic [CNT_W-1:0] cnt1,
  input logic [CNT_W-1:0] lat0,
  input logic             run0,
  input logic             mode16,
  input logic [2:0]       src1,
  input logic             restart0,
  input logic             restart1,
  input logic             step0,
  input logic             wrap0,
  input logic             flag0,
  input logic             ien0,
  input logic             irq0,
  input logic             wave_en,
  input logic             wave_out,
  input logic             bus_wr,
  input logic [2:0]       bus_addr,
  input logic [7:0]       bus_wdata
);
  p_match_clear_r3: assert property (@(posedge clk) disable iff (rst)
    (step0 && !mode16 && cnt0 == lat0) |=> (cnt0 == '0));

  p_latch_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (run0 && !wrap0 && !restart0) |=> $stable(lat0));

  p_t1_no_ext_r2: assert property (@(posedge clk) disable iff (rst)
    (!mode16 && src1 == 3'd7 && !restart1) |=> $stable(cnt1));

  p_stop_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!run0 && !restart0) |=> $stable(cnt0));

  p_flag_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (flag0 && !(bus_wr && bus_addr == 3'd0 && !bus_wdata[6])) |=> flag0);

  p_irq_set_r6: assert property (@(posedge clk) disable iff (rst)
    (flag0 && ien0) |=> irq0);

  p_irq_clr_r6: assert property (@(posedge clk) disable iff (rst)
    !(flag0 && ien0) |=> !irq0);

  p_wave_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !wave_en |=> $stable(wave_out));
endmodule

bind casc_interval_timer cit_checker #(.CNT_W(CNT_W)) u_cit_checker (
  .clk(clk), .rst(rst), .cnt0(cnt0), .cnt1(cnt1), .lat0(lat0),
  .run0(ctl0.run), .mode16(mode16), .src1(ctl1.src),
  .restart0(restart0), .restart1(restart1), .step0(step0), .wrap0(wrap0),
  .flag0(ctl0.flag), .ien0(ctl0.ien), .irq0(irq0),
  .wave_en(wave_en), .wave_out(wave_out),
  .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata));

// File: tb/test_casc_interval_timer.sv
`timescale 1ns/1ps
module test_casc_interval_timer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [6:0] tick_in = '0;
  logic       ext_clk = 1'b0;
  logic       bus_wr = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq0, irq1, wave_out;
  int         n_run = 0, n_fail = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  casc_interval_timer i_casc_interval_timer (
    .clk(clk), .rst(rst), .tick_in(tick_in), .ext_clk(ext_clk),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq0(irq0), .irq1(irq1), .wave_out(wave_out));

  function automatic logic [7:0] ctl(bit run, bit fall, int src, bit ien, bit flag, bit m16);
    return {m16, flag, ien, 3'(src), fall, run};
  endfunction
  function automatic int exp_cnt(int n, int l); return n % (l + 1); endfunction
  function automatic int exp_hits(int n, int l); return n / (l + 1); endfunction

  task automatic check(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a;
    @(negedge clk); d = bus_rdata;
  endtask

  task automatic pulse(int idx, int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick_in[idx] = 1'b1;
      @(negedge clk); tick_in[idx] = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic ext_pulse(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); ext_clk = 1'b1;
      repeat (4) @(negedge clk);
      ext_clk = 1'b0;
      repeat (4) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    bit exp_wave;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R9 / R10: reset state
    for (int a = 0; a < 7; a++) begin
      rd(3'(a), v);
      check("R9 reset register", v, 0);
    end
    check("R9 irq0 reset", irq0, 0);
    check("R9 wave reset", wave_out, 0);

    // R1/R3/R6: directed count, match, flag, irq
    wr(3'd2, 8'd4);
    wr(3'd0, ctl(1, 0, 3, 1, 1, 0));
    pulse(3, 3);
    rd(3'd4, v); check("R1 count rising", v, 3);
    check("R6 no irq before match", irq0, 0);
    pulse(3, 2);
    rd(3'd4, v); check("R3 clear after L+1", v, 0);
    rd(3'd0, v); check("R6 flag set", v[6], 1);
    check("R6 irq0 asserted", irq0, 1);
    wr(3'd0, ctl(1, 0, 3, 1, 1, 0));
    rd(3'd0, v); check("R6 write 1 keeps flag", v[6], 1);
    wr(3'd0, ctl(1, 0, 3, 1, 0, 0));
    rd(3'd0, v); check("R6 write 0 clears flag", v[6], 0);
    check("R6 irq0 released", irq0, 0);

    // R4: double buffering (current latch 4, count 0)
    wr(3'd0, ctl(0, 0, 3, 0, 0, 0));
    wr(3'd2, 8'd3);
    wr(3'd0, ctl(1, 0, 3, 0, 0, 0));
    pulse(3, 2);
    wr(3'd2, 8'd5);
    pulse(3, 2);
    rd(3'd4, v); check("R4 old latch used until match", v, 0);
    pulse(3, 5);
    rd(3'd4, v); check("R4 new latch after match", v, 5);
    pulse(3, 1);
    rd(3'd4, v); check("R4 new period ends", v, 0);
    rd(3'd0, v); check("R6 flag set with ien 0", v[6], 1);
    check("R6 irq gated by enable", irq0, 0);

    // R8: stop holds, restart clears
    pulse(3, 2);
    wr(3'd0, ctl(0, 0, 3, 0, 0, 0));
    pulse(3, 3);
    rd(3'd4, v); check("R8 stopped counter holds", v, 2);
    wr(3'd0, ctl(1, 0, 3, 0, 0, 0));
    rd(3'd4, v); check("R8 restart clears", v, 0);

    // R2: external source, falling edge, timer 0; timer 1 ignores code 7
    wr(3'd0, ctl(0, 1, 7, 0, 0, 0));
    wr(3'd2, 8'd50);
    wr(3'd0, ctl(1, 1, 7, 0, 0, 0));
    wr(3'd1, ctl(1, 0, 7, 0, 0, 0));
    ext_pulse(6);
    rd(3'd4, v); check("R2 ext falling edges counted", v, 6);
    rd(3'd5, v); check("R2 timer1 code 7 idle", v, 0);
    wr(3'd1, ctl(0, 0, 0, 0, 0, 0));

    // R1: falling-edge mode on an internal tick, timer 1
    wr(3'd3, 8'd9);
    wr(3'd1, ctl(1, 1, 5, 1, 0, 0));
    pulse(5, 4);
    rd(3'd5, v); check("R1 timer1 falling tick", v, 4);
    wr(3'd1, ctl(0, 1, 5, 1, 0, 0));

    // R5: 16-bit cascade, limit 0x012C
    wr(3'd0, ctl(0, 0, 2, 1, 0, 0));
    wr(3'd2, 8'h2C);
    wr(3'd3, 8'h01);
    wr(3'd6, 8'h01);
    wr(3'd0, ctl(1, 0, 2, 1, 0, 1));
    pulse(2, 300);
    rd(3'd4, v); check("R5 low byte", v, 8'h2C);
    rd(3'd5, v); check("R5 high byte carry", v, 8'h01);
    check("R5 no irq before 16-bit match", irq0, 0);
    pulse(2, 1);
    rd(3'd4, v); check("R5 low cleared", v, 0);
    rd(3'd5, v); check("R5 high cleared", v, 0);
    check("R5 irq0 on combined match", irq0, 1);
    check("R5 irq1 stays low", irq1, 0);
    check("R7 wave flips on combined match", wave_out, 1);
    exp_wave = 1'b1;
    wr(3'd0, ctl(0, 0, 2, 0, 0, 0));

    // R7: wave disabled holds
    wr(3'd6, 8'h00);
    wr(3'd2, 8'd1);
    wr(3'd0, ctl(1, 0, 2, 0, 0, 0));
    pulse(2, 4);
    check("R7 wave holds when disabled", wave_out, exp_wave);
    wr(3'd0, ctl(0, 0, 2, 0, 0, 0));

    // R1/R3/R6/R7: constrained random intervals
    for (int it = 0; it < 24; it++) begin
      int ch, l, n, src, hits;
      bit fall;
      ch   = int'($urandom % 2);
      l    = 1 + int'($urandom % 12);
      n    = int'($urandom % 40);
      src  = int'($urandom % 7);
      fall = 1'($urandom % 2);
      wr(3'(ch), ctl(0, fall, src, 1, 0, 0));
      wr(3'(2 + ch), 8'(l));
      wr(3'd6, {6'b0, 1'(ch), 1'b1});
      wr(3'(ch), ctl(1, fall, src, 1, 0, 0));
      pulse(src, n);
      hits = exp_hits(n, l);
      if (hits % 2 == 1) exp_wave = ~exp_wave;
      rd(3'(4 + ch), v); check("R1 R3 random count", v, exp_cnt(n, l));
      rd(3'(ch), v); check("R6 random flag", v[6], hits > 0);
      check("R6 random irq", ch == 0 ? irq0 : irq1, hits > 0);
      check("R7 random wave", wave_out, exp_wave);
      wr(3'(ch), ctl(0, fall, src, 1, 0, 0));
    end

    finish_run();
  end
endmodule